// File: doc/BRIEF.md
# I2C Register-Write Slave

This block is the write-only slave side of a two-wire serial control bus. It feeds a bank of 21 eight-bit control registers at addresses 0x00 to 0x14. It runs on a fast system clock. It passes the bus clock and data lines through a synchronizer and finds START and STOP conditions and clock edges in the sampled stream. It then decodes the frame that follows a START.

The first byte of a frame carries a 7-bit device address and a direction bit. The device address is a fixed prefix followed by two strap pins. When the address matches and the frame is a write, the block acknowledges by pulling the data line low. It then takes a register sub-address and one or more data bytes. The register address advances after every data byte and wraps back to zero after the last register.

Each write appears on a one-cycle strobe together with its address and data. The whole register bank is also available as one flat output vector.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset all registers read zero, `sda_pull` is 0 (line released) and `wr_en` is 0.
- R2: A first byte whose upper seven bits equal `{5'b00100, strap_addr}` and whose bit 0 (direction) is 0 is acknowledged: `sda_pull` is 1 during the ninth SCL high period.
- R3: A first byte with a different address, or with bit 0 equal to 1, is not acknowledged. Every later byte up to the next START is then ignored: no acknowledge and no register change.
- R4: The second byte is the sub-address. It is always acknowledged. Its lower five bits give the starting register, and its upper three bits are ignored.
- R5: `sda_pull` changes only while the synchronized SCL is low, that is, after a detected SCL falling edge or at a START or STOP.
- R6: Each data byte, received MSB first, is acknowledged. It is written to the current register with a one-cycle `wr_en` pulse. The current address then increments by one.
- R7: After a write to register 0x14 the next data byte goes to register 0x00.
- R8: A data byte aimed at an address from 0x15 to 0x1F is acknowledged but discarded, with no `wr_en` pulse. The next address is 0x00.
- R9: A repeated START restarts address reception. After a STOP, bytes clocked without a new START are ignored.
- R10: `regs_flat[8*i +: 8]` holds register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_addr | input | 2 | Pin-strapped low bits of the device address |
| sda_pull | output | 1 | 1 = drive the data line low (open-drain enable) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register address of the current write |
| wr_data | output | 8 | Data of the current write |
| regs_flat | output | 168 | All 21 registers, register i at bits 8*i+7 to 8*i |

## Verification
A table of burst writes drives the main path with different sub-addresses and burst lengths:
- a plain three-byte burst from zero, which shows that the address increments;
- bursts that start at or next to register 0x14, which show the wrap;
- bursts that start in the 0x15 to 0x1F hole, which show that writes are dropped and the address still wraps;
- a sub-address with its high bits set, which shows that those bits are masked.

Directed frames cover the other cases:
- a foreign address and a read request, which separate matching from rejection;
- a changed strap value, which shows that the strap pins feed the address match;
- a repeated START, which shows that address reception restarts;
- bytes clocked after a STOP, which show that the bus is idle.

The bench counts write strobes as well, so a dropped write is told apart from a write of unchanged data.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DEVADR,
    PH_SUBADR,
    PH_DATA
  } phase_t;

  // First byte selects this device: 7-bit address match and write direction.
  function automatic logic dev_match(input logic [DATA_W-1:0] b,
                                     input logic [4:0] prefix,
                                     input logic [1:0] strap);
    return (b[7:1] == {prefix, strap}) && !b[0];
  endfunction

  // Register pointer after one data byte: step, or return to zero past the last register.
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a,
                                                  input int last);
    if (int'(a) >= last) return '0;
    return a + 5'd1;
  endfunction

endpackage

// File: rtl/i2c_regwr_sync.sv
module i2c_regwr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_hi,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_hi;
      sda_d <= sda_bit;
    end
  end

  assign scl_hi    = scl_pipe[SYNC_STAGES-1];
  assign sda_bit   = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_hi & ~scl_d;
  assign scl_fall  = ~scl_hi & scl_d;
  assign start_det = scl_hi & scl_d & sda_d & ~sda_bit;
  assign stop_det  = scl_hi & scl_d & ~sda_d & sda_bit;

endmodule

// File: rtl/i2c_regwr_engine.sv
module i2c_regwr_engine
  import i2c_regwr_pkg::*;
#(
  parameter int         NUM_REGS   = 21,
  parameter logic [4:0] DEV_PREFIX = 5'b00100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_hi,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        strap_addr,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int LAST  = NUM_REGS - 1;
  localparam int CNT_W = $clog2(DATA_W + 1);

  phase_t             phase;
  logic [CNT_W-1:0]   bit_cnt;
  logic               in_ack;
  logic [DATA_W-1:0]  shreg;
  logic [ADDR_W-1:0]  cur_addr;

  // Named events for the checks below.
  logic byte_done, dev_hit, in_range;
  assign byte_done = (bit_cnt == CNT_W'(DATA_W));
  assign dev_hit   = dev_match(shreg, DEV_PREFIX, strap_addr);
  assign in_range  = int'(cur_addr) < NUM_REGS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      shreg    <= '0;
      cur_addr <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase    <= PH_DEVADR;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !byte_done) begin
          shreg   <= {shreg[DATA_W-2:0], sda_bit};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall && in_ack) begin
          in_ack   <= 1'b0;
          sda_pull <= 1'b0;
          bit_cnt  <= '0;
        end else if (scl_fall && byte_done) begin
          unique case (phase)
            PH_DEVADR: begin
              if (dev_hit) begin
                in_ack   <= 1'b1;
                sda_pull <= 1'b1;
                phase    <= PH_SUBADR;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_SUBADR: begin
              in_ack   <= 1'b1;
              sda_pull <= 1'b1;
              cur_addr <= shreg[ADDR_W-1:0];
              phase    <= PH_DATA;
            end
            PH_DATA: begin
              in_ack   <= 1'b1;
              sda_pull <= 1'b1;
              if (in_range) begin
                wr_en   <= 1'b1;
                wr_addr <= cur_addr;
                wr_data <= shreg;
              end
              cur_addr <= addr_next(cur_addr, LAST);
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  AST_SDA_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_hi); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R6

  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == LAST) |-> (cur_addr == '0)); // R7

endmodule

// File: rtl/i2c_regwr_bank.sv
module i2c_regwr_bank
  import i2c_regwr_pkg::*;
#(
  parameter int NUM_REGS = 21
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                regs_q[g] <= '0;
        else if (wr_en && int'(wr_addr) == g)      regs_q[g] <= wr_data;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end
  endgenerate

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NUM_REGS)); // R8

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(wr_addr)] == $past(wr_data))); // R6

endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
  import i2c_regwr_pkg::*;
#(
  parameter int         NUM_REGS    = 21,
  parameter logic [4:0] DEV_PREFIX  = 5'b00100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  input  logic [1:0]                 strap_addr,
  output logic                       sda_pull,
  output logic                       wr_en,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  logic scl_hi, sda_bit, scl_rise, scl_fall, start_det, stop_det;

  i2c_regwr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_hi    (scl_hi),
    .sda_bit   (sda_bit),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_regwr_engine #(.NUM_REGS(NUM_REGS), .DEV_PREFIX(DEV_PREFIX)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_hi     (scl_hi),
    .sda_bit    (sda_bit),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_addr (strap_addr),
    .sda_pull   (sda_pull),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  i2c_regwr_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .regs_flat (regs_flat)
  );

endmodule

// File: tb/sim_i2c_regwr_slave.sv
`timescale 1ns/1ps
module sim_i2c_regwr_slave;

  localparam int NREG = 21;
  localparam int Q    = 8;   // quarter SCL period in clk cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_pull, wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [NREG*8-1:0] regs_flat;
  logic sda_line;

  int n_checks = 0;
  int n_fail = 0;
  int strobes = 0;
  logic [7:0] model [NREG];

  always #2 clk = ~clk;   // 250 MHz

  assign sda_line = sda_drv & ~sda_pull;

  i2c_regwr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
    .strap_addr(strap), .sda_pull(sda_pull), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs_flat(regs_flat)
  );

  always @(posedge clk) if (wr_en) strobes <= strobes + 1;

  // {count, sub-address, d0, d1, d2}
  localparam logic [33:0] VEC [6] = '{
    {2'd3, 8'h00, 8'h11, 8'h22, 8'h33},
    {2'd3, 8'h13, 8'hA1, 8'hA2, 8'hA3},
    {2'd1, 8'h14, 8'h5C, 8'h00, 8'h00},
    {2'd2, 8'h17, 8'hEE, 8'hEF, 8'h00},
    {2'd1, 8'h2A, 8'h77, 8'h00, 8'h00},
    {2'd2, 8'h1F, 8'h01, 8'h02, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    int bad = -1;
    n_checks++;
    for (int i = NREG - 1; i >= 0; i--)
      if (regs_flat[i*8 +: 8] !== model[i]) bad = i;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s reg%0d actual=%0h expected=%0h", req, bad,
               regs_flat[bad*8 +: 8], model[bad]);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(Q);
      scl_drv = 1'b1; tick(2*Q);
      scl_drv = 1'b0; tick(Q);
    end
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    acked = ~sda_line;
    tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  // Bench-side model of a data byte landing in the bank.
  function automatic logic [4:0] model_write(input logic [4:0] a, input logic [7:0] d);
    if (a <= 5'h14) model[a] = d;
    return (a < 5'h14) ? a + 5'd1 : 5'd0;
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [4:0] pa;
    int s0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(5);
    // R1: reset state
    check("R1 regs zero", {31'b0, regs_flat == '0}, 32'd1);
    check("R1 sda released", {31'b0, sda_pull}, 32'd0);
    check("R1 no strobe", {31'b0, wr_en}, 32'd0);
    rst_n = 1'b1;
    tick(10);

    // Table of burst writes
    for (int v = 0; v < 6; v++) begin
      string tag;
      int n;
      int exp_str;
      logic [7:0] d [3];
      tag = (v == 0) ? "R6" : (v < 3) ? "R7" : (v == 4) ? "R4" : "R8";
      n = int'(VEC[v][33:32]);
      d[0] = VEC[v][23:16]; d[1] = VEC[v][15:8]; d[2] = VEC[v][7:0];
      s0 = strobes;
      exp_str = 0;
      bus_start();
      send_byte(8'h22, ack);
      check("R2 address ack", {31'b0, ack}, 32'd1);
      send_byte(VEC[v][31:24], ack);
      check("R4 sub-address ack", {31'b0, ack}, 32'd1);
      pa = VEC[v][28:24];
      for (int j = 0; j < n; j++) begin
        send_byte(d[j], ack);
        check("R6 data ack", {31'b0, ack}, 32'd1);
        if (pa <= 5'h14) exp_str++;
        pa = model_write(pa, d[j]);
      end
      bus_stop();
      check("R5 released after stop", {31'b0, sda_pull}, 32'd0);
      check_regs(tag);
      check({tag, " strobe count"}, strobes - s0, exp_str);
    end

    // R3: foreign address
    s0 = strobes;
    bus_start();
    send_byte(8'h24, ack);
    check("R3 foreign address no ack", {31'b0, ack}, 32'd0);
    send_byte(8'h01, ack);
    send_byte(8'h99, ack);
    check("R3 later byte no ack", {31'b0, ack}, 32'd0);
    bus_stop();
    check_regs("R3 foreign unchanged");
    check("R3 foreign no strobe", strobes - s0, 0);

    // R3: read direction
    bus_start();
    send_byte(8'h23, ack);
    check("R3 read no ack", {31'b0, ack}, 32'd0);
    send_byte(8'h02, ack);
    send_byte(8'h55, ack);
    bus_stop();
    check_regs("R3 read unchanged");
    check("R3 read no strobe", strobes - s0, 0);

    // R2: strap pins feed the match
    strap = 2'b10;
    tick(4);
    bus_start();
    send_byte(8'h24, ack);
    check("R2 strap address ack", {31'b0, ack}, 32'd1);
    send_byte(8'h09, ack);
    send_byte(8'h3C, ack);
    bus_stop();
    model[9] = 8'h3C;
    check_regs("R2 strap write");
    strap = 2'b01;
    tick(4);

    // R9: repeated START
    bus_start();
    send_byte(8'h22, ack);
    send_byte(8'h05, ack);
    send_byte(8'h44, ack);
    bus_start();
    send_byte(8'h22, ack);
    check("R9 repeated start address ack", {31'b0, ack}, 32'd1);
    send_byte(8'h06, ack);
    send_byte(8'h55, ack);
    bus_stop();
    model[5] = 8'h44; model[6] = 8'h55;
    check_regs("R9 repeated start writes");

    // R9: bytes after STOP without START are ignored
    s0 = strobes;
    send_byte(8'h22, ack);
    check("R9 after stop no ack", {31'b0, ack}, 32'd0);
    send_byte(8'h07, ack);
    send_byte(8'hF0, ack);
    check_regs("R9 after stop unchanged");
    check("R9 after stop no strobe", strobes - s0, 0);

    // R10: flat layout of the top register
    check("R10 reg20 position", {24'b0, regs_flat[20*8 +: 8]}, {24'b0, model[20]});

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule